// File: doc/BRIEF.md
# Transmit/Receive Byte FIFO Pair with Trigger-Level Interrupts

This block sits between a serial shift engine and the register bus of a serial-port controller. It holds two byte queues. Software pushes bytes into the transmit queue and the shift engine drains them. The shift engine pushes received bytes into the receive queue and software drains them. Each queue has a programmable threshold. Crossing a threshold raises a sticky status bit, and it can also raise a level-type request line for an external DMA engine.

A small interrupt unit holds four status sources: receive ready, transmit refill request, receive overflow and transfer complete. Each source has an enable bit, and a single interrupt line summarises them. Software clears status bits by writing ones. A threshold condition that still holds after the clear shows up again at once.

The control word carries the two thresholds, the two DMA enables and two self-clearing flush commands. Register decode is left to the surrounding bus logic. Each register has its own write strobe and read port.

Top module: `dual_byte_fifo_irq`

## Requirements
- R1: While reset is held, all counts, status bits, enable bits and control fields read 0, and `irq`, `rx_dma_req` and `tx_dma_req` are low.
- R2: Each queue returns bytes in the order they were pushed. `fstat_rdata[7:0]` holds the receive occupancy and `fstat_rdata[23:16]` holds the transmit occupancy; both update on the clock edge that accepts a push or a pop.
- R3: A receive push that arrives while the receive queue holds DEPTH bytes (with no pop in the same cycle) is discarded. On that edge it sets status bit 8, and the stored bytes are left unchanged.
- R4: A transmit push into a full transmit queue is discarded. The count stays at DEPTH and no status bit records the loss.
- R5: Status bit 0 is set on every edge at which the receive count is greater than or equal to the receive threshold in control bits 7:0.
- R6: Status bit 4 is set on every edge at which the transmit count is less than or equal to the transmit threshold in control bits 23:16.
- R7: A one-cycle `xfer_done` pulse sets status bit 12 on that edge.
- R8: Writing a 1 to a status bit through `ista_we` clears it, and writing a 0 leaves it unchanged. If the bit's set condition holds in the same cycle as the clear, the set wins.
- R9: `irq` is high exactly when some status bit and its enable bit are both set. The enable register uses the status layout (bits 0, 4, 8, 12), and all other enable bits read 0.
- R10: `rx_dma_req` equals control bit 8 AND (receive count >= receive threshold). `tx_dma_req` equals control bit 24 AND (transmit count <= transmit threshold). Both follow the current counts with no extra delay.
- R11: Writing control bit 15 empties the receive queue, and writing bit 31 empties the transmit queue. The other queue is untouched, both bits always read back 0, and the other fields in the same write take effect.
- R12: A pop from an empty queue has no effect: the count stays 0 and later pushes are read back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word readback |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 32 | Interrupt enable write data |
| ien_rdata | output | 32 | Interrupt enable readback |
| ista_we | input | 1 | Status write-one-to-clear strobe |
| ista_wdata | input | 32 | Status clear mask |
| ista_rdata | output | 32 | Interrupt status |
| fstat_rdata | output | 32 | Queue occupancy counts |
| tx_push | input | 1 | Software push into transmit queue |
| tx_wdata | input | 8 | Byte pushed into transmit queue |
| tx_pop | input | 1 | Shift engine pop from transmit queue |
| tx_rdata | output | 8 | Head of transmit queue |
| rx_push | input | 1 | Shift engine push into receive queue |
| rx_wdata | input | 8 | Byte pushed into receive queue |
| rx_pop | input | 1 | Software pop from receive queue |
| rx_rdata | output | 8 | Head of receive queue |
| xfer_done | input | 1 | One-cycle transfer-complete pulse |
| rx_dma_req | output | 1 | Receive DMA request level |
| tx_dma_req | output | 1 | Transmit DMA request level |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `xfer_done` is a pulse and is not held across a clear of its own bit. The overflow and flush properties further assume that nothing pushes in the same cycle as a flush of that queue. The bench drives every strobe for exactly one cycle and never overlaps a flush with a push. The exhaustive threshold sweeps step the counts one push at a time, so every threshold is compared against every occupancy of a small queue.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
    // control word layout
    localparam int RX_TRIG_LSB  = 0;
    localparam int RX_DMA_BIT   = 8;
    localparam int RX_FLUSH_BIT = 15;
    localparam int TX_TRIG_LSB  = 16;
    localparam int TX_DMA_BIT   = 24;
    localparam int TX_FLUSH_BIT = 31;
    localparam int TRIG_W       = 8;

    // interrupt sources, each at bit SRC_STRIDE*index
    localparam int NUM_SRC      = 4;
    localparam int SRC_STRIDE   = 4;
    localparam int SRC_RX_RDY   = 0;
    localparam int SRC_TX_REQ   = 1;
    localparam int SRC_RX_OVF   = 2;
    localparam int SRC_DONE     = 3;

    typedef struct packed {
        logic              tx_dma;
        logic [TRIG_W-1:0] tx_trig;
        logic              rx_dma;
        logic [TRIG_W-1:0] rx_trig;
    } ctrl_t;

    function automatic logic [31:0] src_to_word(input logic [NUM_SRC-1:0] v);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < NUM_SRC; i++) w[SRC_STRIDE*i] = v[i];
        return w;
    endfunction

    function automatic logic [NUM_SRC-1:0] word_to_src(input logic [31:0] w);
        logic [NUM_SRC-1:0] v;
        for (int i = 0; i < NUM_SRC; i++) v[i] = w[SRC_STRIDE*i];
        return v;
    endfunction
endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
    parameter int DEPTH = 128,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DW-1:0]              wdata,
    input  logic                       pop,
    output logic [DW-1:0]              rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t s_d, s_q;
    logic [DW-1:0] mem [DEPTH];
    logic full_q, empty_q, do_push, do_pop;

    assign full_q  = (s_q.cnt == CW'(DEPTH));
    assign empty_q = (s_q.cnt == '0);
    assign do_pop  = pop && !empty_q && !flush;
    assign do_push = push && !flush && (!full_q || do_pop);
    assign drop    = push && !flush && full_q && !do_pop;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wr = (s_q.wr == LAST) ? '0 : s_q.wr + 1'b1;
            if (do_pop)  s_d.rd = (s_q.rd == LAST) ? '0 : s_q.rd + 1'b1;
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wr] <= wdata;
    end

    assign rdata = mem[s_q.rd];
    assign count = s_q.cnt;
endmodule

// File: rtl/queue_ctrl_reg.sv
module queue_ctrl_reg
    import fifo_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  logic [31:0] ctrl_wdata,
    output ctrl_t       ctrl,
    output logic        rx_flush,
    output logic        tx_flush,
    output logic [31:0] ctrl_rdata
);
    ctrl_t c_d, c_q;
    logic  unused_bits;

    assign unused_bits = ^{ctrl_wdata[RX_FLUSH_BIT-1:RX_DMA_BIT+1],
                           ctrl_wdata[TX_FLUSH_BIT-1:TX_DMA_BIT+1]};

    always_comb begin
        c_d = c_q;
        if (ctrl_we) begin
            c_d.rx_trig = ctrl_wdata[RX_TRIG_LSB +: TRIG_W];
            c_d.rx_dma  = ctrl_wdata[RX_DMA_BIT];
            c_d.tx_trig = ctrl_wdata[TX_TRIG_LSB +: TRIG_W];
            c_d.tx_dma  = ctrl_wdata[TX_DMA_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // flush commands act as pulses and are never stored
    assign rx_flush = ctrl_we && ctrl_wdata[RX_FLUSH_BIT];
    assign tx_flush = ctrl_we && ctrl_wdata[TX_FLUSH_BIT];
    assign ctrl     = c_q;

    always_comb begin
        ctrl_rdata = '0;
        ctrl_rdata[RX_TRIG_LSB +: TRIG_W] = c_q.rx_trig;
        ctrl_rdata[RX_DMA_BIT]            = c_q.rx_dma;
        ctrl_rdata[TX_TRIG_LSB +: TRIG_W] = c_q.tx_trig;
        ctrl_rdata[TX_DMA_BIT]            = c_q.tx_dma;
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_we,
    input  logic [N-1:0] clr_vec,
    input  logic         en_we,
    input  logic [N-1:0] en_vec,
    output logic [N-1:0] sta,
    output logic [N-1:0] en,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] sta;
        logic [N-1:0] en;
    } istate_t;

    istate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en_we) s_d.en = en_vec;
        // a set condition in the clear cycle wins over the clear
        s_d.sta = (s_q.sta & ~(clr_we ? clr_vec : '0)) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sta = s_q.sta;
    assign en  = s_q.en;
    assign irq = |(s_q.sta & s_q.en);
endmodule

// File: rtl/dual_byte_fifo_irq.sv
module dual_byte_fifo_irq
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  logic [31:0] ctrl_wdata,
    output logic [31:0] ctrl_rdata,
    input  logic        ien_we,
    input  logic [31:0] ien_wdata,
    output logic [31:0] ien_rdata,
    input  logic        ista_we,
    input  logic [31:0] ista_wdata,
    output logic [31:0] ista_rdata,
    output logic [31:0] fstat_rdata,
    input  logic        tx_push,
    input  logic [7:0]  tx_wdata,
    input  logic        tx_pop,
    output logic [7:0]  tx_rdata,
    input  logic        rx_push,
    input  logic [7:0]  rx_wdata,
    input  logic        rx_pop,
    output logic [7:0]  rx_rdata,
    input  logic        xfer_done,
    output logic        rx_dma_req,
    output logic        tx_dma_req,
    output logic        irq
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int CMP = ((CW > TRIG_W) ? CW : TRIG_W) + 1;

    ctrl_t              ctrl;
    logic               rx_flush, tx_flush, rx_drop, tx_drop;
    logic [CW-1:0]      rx_cnt, tx_cnt;
    logic               rx_lvl, tx_lvl, unused_tx_drop;
    logic [NUM_SRC-1:0] set_vec, sta, en;

    queue_ctrl_reg u_ctrl (
        .clk, .rst_n, .ctrl_we, .ctrl_wdata,
        .ctrl(ctrl), .rx_flush(rx_flush), .tx_flush(tx_flush),
        .ctrl_rdata(ctrl_rdata)
    );

    byte_queue #(.DEPTH(DEPTH), .DW(8)) u_txq (
        .clk, .rst_n, .flush(tx_flush), .push(tx_push), .wdata(tx_wdata),
        .pop(tx_pop), .rdata(tx_rdata), .count(tx_cnt), .drop(tx_drop)
    );

    byte_queue #(.DEPTH(DEPTH), .DW(8)) u_rxq (
        .clk, .rst_n, .flush(rx_flush), .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .rdata(rx_rdata), .count(rx_cnt), .drop(rx_drop)
    );

    // a full transmit queue silently discards
    assign unused_tx_drop = tx_drop;

    assign rx_lvl = CMP'(rx_cnt) >= CMP'(ctrl.rx_trig);
    assign tx_lvl = CMP'(tx_cnt) <= CMP'(ctrl.tx_trig);

    always_comb begin
        set_vec             = '0;
        set_vec[SRC_RX_RDY] = rx_lvl;
        set_vec[SRC_TX_REQ] = tx_lvl;
        set_vec[SRC_RX_OVF] = rx_drop;
        set_vec[SRC_DONE]   = xfer_done;
    end

    irq_status_unit #(.N(NUM_SRC)) u_irq (
        .clk, .rst_n, .set_vec(set_vec),
        .clr_we(ista_we), .clr_vec(word_to_src(ista_wdata)),
        .en_we(ien_we), .en_vec(word_to_src(ien_wdata)),
        .sta(sta), .en(en), .irq(irq)
    );

    assign ista_rdata = src_to_word(sta);
    assign ien_rdata  = src_to_word(en);
    assign rx_dma_req = ctrl.rx_dma && rx_lvl;
    assign tx_dma_req = ctrl.tx_dma && tx_lvl;

    always_comb begin
        fstat_rdata = '0;
        fstat_rdata[7:0]   = 8'(rx_cnt);
        fstat_rdata[23:16] = 8'(tx_cnt);
    end
endmodule

// File: rtl/dual_byte_fifo_irq_chk.sv
module dual_byte_fifo_irq_chk #(
    parameter int DEPTH = 128
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  rx_cnt,
    input logic [7:0]  tx_cnt,
    input logic        rx_push,
    input logic        rx_pop,
    input logic        flush_rx_cmd,
    input logic        ovf_bit,
    input logic        done_bit,
    input logic        xfer_done,
    input logic        clr_done_cmd,
    input logic        rx_dma_en,
    input logic        rx_dma_req,
    input logic [31:0] ien_rdata,
    input logic        irq
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_pop && !flush_rx_cmd && rx_cnt == 8'(DEPTH)) |=> (ovf_bit && rx_cnt == 8'(DEPTH)));

    assert_tx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= 8'(DEPTH));

    assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> done_bit);

    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done_cmd && !xfer_done) |=> !done_bit);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_rdata == 32'd0) |-> !irq);

    assert_dma_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_dma_en |-> !rx_dma_req);

    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_rx_cmd |=> (rx_cnt == 8'd0));

    assert_empty_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && !flush_rx_cmd && rx_cnt == 8'd0) |=> (rx_cnt == 8'd0));
endmodule

bind dual_byte_fifo_irq dual_byte_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .rx_cnt(fstat_rdata[7:0]),
    .tx_cnt(fstat_rdata[23:16]),
    .rx_push(rx_push),
    .rx_pop(rx_pop),
    .flush_rx_cmd(ctrl_we && ctrl_wdata[15]),
    .ovf_bit(ista_rdata[8]),
    .done_bit(ista_rdata[12]),
    .xfer_done(xfer_done),
    .clr_done_cmd(ista_we && ista_wdata[12]),
    .rx_dma_en(ctrl_rdata[8]),
    .rx_dma_req(rx_dma_req),
    .ien_rdata(ien_rdata),
    .irq(irq)
);

// File: tb/dual_byte_fifo_irq_tb.sv
module dual_byte_fifo_irq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0, ien_we = 1'b0, ista_we = 1'b0;
    logic [31:0] ctrl_wdata = '0, ien_wdata = '0, ista_wdata = '0;
    logic [31:0] ctrl_rdata, ien_rdata, ista_rdata, fstat_rdata;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0]  tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
    logic        xfer_done = 1'b0;
    logic        rx_dma_req, tx_dma_req, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_byte_fifo_irq #(.DEPTH(DEPTH)) u_dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk_ctrl(input logic [7:0] rxt, input logic rxd, input logic rxf,
                                            input logic [7:0] txt, input logic txd, input logic txf);
        return {txf, 6'd0, txd, txt, rxf, 6'd0, rxd, rxt};
    endfunction

    task automatic wr_ctrl(input logic [31:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v; step(); ctrl_we = 1'b0;
    endtask
    task automatic wr_ien(input logic [31:0] v);
        ien_we = 1'b1; ien_wdata = v; step(); ien_we = 1'b0;
    endtask
    task automatic clr_sta(input logic [31:0] v);
        ista_we = 1'b1; ista_wdata = v; step(); ista_we = 1'b0;
    endtask
    task automatic rx_put(input logic [7:0] b);
        rx_push = 1'b1; rx_wdata = b; step(); rx_push = 1'b0;
    endtask
    task automatic tx_put(input logic [7:0] b);
        tx_push = 1'b1; tx_wdata = b; step(); tx_push = 1'b0;
    endtask
    task automatic rx_take();
        rx_pop = 1'b1; step(); rx_pop = 1'b0;
    endtask
    task automatic tx_take();
        tx_pop = 1'b1; step(); tx_pop = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    initial begin
        // R1: outputs while reset is held
        step(); step();
        check("R1 fstat", fstat_rdata, 32'd0);
        check("R1 ista", ista_rdata, 32'd0);
        check("R1 ien", ien_rdata, 32'd0);
        check("R1 ctrl", ctrl_rdata, 32'd0);
        check("R1 irq/dma", {29'd0, irq, rx_dma_req, tx_dma_req}, 32'd0);
        rst_n = 1'b1;
        step();

        // R2: ordering and count fields
        for (int i = 0; i < DEPTH; i++) begin
            rx_put(pat(i));
            check("R2 rx count", fstat_rdata[7:0], 32'(i + 1));
            tx_put(pat(i + 50));
            check("R2 tx count", fstat_rdata[23:16], 32'(i + 1));
        end

        // R3: push into full receive queue
        clr_sta(32'h0000_1111);
        rx_put(8'hEE);
        check("R3 ovf bit", ista_rdata[8], 1'b1);
        check("R3 rx count", fstat_rdata[7:0], 32'(DEPTH));
        // R4: push into full transmit queue
        clr_sta(32'h0000_0100);
        tx_put(8'hEE);
        check("R4 tx count", fstat_rdata[23:16], 32'(DEPTH));
        check("R4 no ovf", ista_rdata[8], 1'b0);

        for (int i = 0; i < DEPTH; i++) begin
            check("R2 R3 rx order", rx_rdata, pat(i));
            rx_take();
            check("R2 tx order", tx_rdata, pat(i + 50));
            tx_take();
        end
        check("R2 both empty", fstat_rdata, 32'd0);

        // R5 R8 R10: receive threshold sweep against every occupancy
        for (int t = 0; t <= DEPTH; t++) begin
            wr_ctrl(mk_ctrl(8'(t), 1'b1, 1'b1, 8'd0, 1'b0, 1'b0));
            for (int n = 0; n <= DEPTH; n++) begin
                check("R10 rx dma", rx_dma_req, (n >= t));
                clr_sta(32'h0000_0001);
                check("R5 R8 rx ready", ista_rdata[0], (n >= t));
                if (n < DEPTH) rx_put(pat(n));
            end
        end

        // R6 R8 R10: transmit threshold sweep
        for (int t = 0; t <= DEPTH; t++) begin
            wr_ctrl(mk_ctrl(8'd0, 1'b0, 1'b0, 8'(t), 1'b1, 1'b1));
            for (int n = 0; n <= DEPTH; n++) begin
                check("R10 tx dma", tx_dma_req, (n <= t));
                clr_sta(32'h0000_0010);
                check("R6 R8 tx request", ista_rdata[4], (n <= t));
                if (n < DEPTH) tx_put(pat(n));
            end
        end

        // R11: independent self-clearing flushes (both queues full now)
        wr_ctrl(mk_ctrl(8'd3, 1'b0, 1'b1, 8'd2, 1'b0, 1'b0));
        check("R11 rx flushed", fstat_rdata[7:0], 32'd0);
        check("R11 tx kept", fstat_rdata[23:16], 32'(DEPTH));
        check("R11 readback", ctrl_rdata, mk_ctrl(8'd3, 1'b0, 1'b0, 8'd2, 1'b0, 1'b0));
        wr_ctrl(mk_ctrl(8'd3, 1'b0, 1'b0, 8'd5, 1'b0, 1'b1));
        check("R11 tx flushed", fstat_rdata[23:16], 32'd0);
        check("R11 readback tx", ctrl_rdata, mk_ctrl(8'd3, 1'b0, 1'b0, 8'd5, 1'b0, 1'b0));

        // R12: pop from empty queue
        rx_take();
        check("R12 rx count", fstat_rdata[7:0], 32'd0);
        tx_take();
        check("R12 tx count", fstat_rdata[23:16], 32'd0);
        rx_put(8'h5A);
        check("R12 rx data", rx_rdata, 8'h5A);
        check("R12 rx count one", fstat_rdata[7:0], 32'd1);
        rx_take();

        // R9: enable layout and masking; R7 R8 transfer complete
        wr_ien(32'hFFFF_FFFF);
        check("R9 ien layout", ien_rdata, 32'h0000_1111);
        wr_ien(32'h0000_1000);
        clr_sta(32'h0000_1000);
        check("R8 done cleared", ista_rdata[12], 1'b0);
        check("R9 irq low", irq, 1'b0);
        xfer_done = 1'b1; step(); xfer_done = 1'b0;
        check("R7 done set", ista_rdata[12], 1'b1);
        check("R9 irq high", irq, 1'b1);
        clr_sta(32'h0000_0000);
        check("R8 zero write keeps", ista_rdata[12], 1'b1);
        xfer_done = 1'b1; ista_we = 1'b1; ista_wdata = 32'h0000_1000; step();
        xfer_done = 1'b0; ista_we = 1'b0;
        check("R8 set beats clear", ista_rdata[12], 1'b1);
        clr_sta(32'h0000_1000);
        check("R8 done w1c", ista_rdata[12], 1'b0);
        check("R9 irq after clear", irq, 1'b0);
        // tx request is pending (count 0 <= 5) but masked
        check("R6 pending", ista_rdata[4], 1'b1);
        check("R9 masked pending", irq, 1'b0);
        wr_ien(32'h0000_0010);
        check("R9 unmasked", irq, 1'b1);
        wr_ien(32'h0000_0000);
        check("R9 mask off", irq, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule